// File: doc/BRIEF.md
# RTC Tick Prescaler and Event Flags

This block is the counting front end of a real-time clock. Four tick inputs, each a one-cycle enable pulse in the system clock domain, stand in for the clock sources. A two-bit field picks one of them. The chosen tick can go through a divide-by-512 stage and then a divide-by-32 stage, each switched in or out on its own. The result advances a free-running 32-bit counter.

A small register bus gives access to three things: the configuration word, a 32-bit status word of sticky event flags, and the counter itself. The flags record a compare match from the RTC logic, an event from the periodic wake-up logic, and counter rollover. Software clears a flag by writing 1 to it. A plain system reset leaves the flags alone; only the power-on reset input clears them. The interrupt output combines each flag with its enable bit.

Counting is controlled by a two-state machine. `CNT_IDLE` holds both dividers cleared and freezes the counter. `CNT_RUN` lets ticks through. The transition `CNT_IDLE`→`CNT_RUN` is taken on the clock edge where `cnt_en` is sampled 1, and `CNT_RUN`→`CNT_IDLE` on the edge where it is sampled 0. In every other case the machine stays in its current state.

Top module: `rtc_front`

## Requirements
- R1: Config bits [1:0] choose the source: code 0 picks `src_tick[0]` (32 kHz crystal), 1 picks `src_tick[1]` (128 kHz internal), 2 picks `src_tick[2]` (16 MHz internal), and 3 picks `src_tick[3]` (fast crystal). Pulses on the unselected inputs have no effect on the counter.
- R2: Config bit 2 set inserts a divide-by-512 stage, so the counter advances on every 512th selected tick. When the bit is clear, the stage is bypassed.
- R3: Config bit 3 set inserts a divide-by-32 stage after the divide-by-512 stage. With both bits set, the total ratio is 16384.
- R4: Writes to config bits [3:0] at address 0 are ignored while `cnt_en` is 1. The enable bits [6:4] (4 RTC, 5 wake-up, 6 rollover) are writable at any time. Config reads back in bits [6:0], and its other bits read 0.
- R5: A selected tick counts only in `CNT_RUN`. The machine enters that state one edge after `cnt_en` is first seen high. In `CNT_IDLE` both dividers return to zero and the counter holds its value.
- R6: A write to address 2 loads the counter only while `cnt_en` is 0, and a load takes priority over a tick in the same cycle. Address 2 reads the counter. Address 3 reads 0.
- R7: The status word at address 1 holds the RTC flag at bit 29, the wake-up flag at bit 13 and the rollover flag at bit 10, counting bit 0 as the LSB. All other bits read 0. `rtc_match` sets the RTC flag and `api_match` sets the wake-up flag.
- R8: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves it unchanged.
- R9: When a set event and a clearing write hit the same flag in the same cycle, the flag ends set.
- R10: The rollover flag sets on the tick that wraps the counter from 0xFFFFFFFF to 0.
- R11: `rst_n` clears the configuration, the counter, the dividers and the state machine, but not the flags. `por_n` clears the flags.
- R12: `irq` is 1 exactly when some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| por_n | input | 1 | Asynchronous power-on reset for the flags, active low |
| src_tick | input | 4 | One-cycle tick pulses from the four sources |
| cnt_en | input | 1 | Count enable; also locks the source and divider fields |
| rtc_match | input | 1 | RTC compare match event |
| api_match | input | 1 | Periodic wake-up event |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 config, 1 status, 2 counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:
- **Divider hand-off.** The bench runs one tick short of and past each divider boundary, including 32767 ticks with both stages in. A design with the stage order or the terminal count off by one shows a different counter value.
- **Config lock.** It writes the source and divider fields while counting. A design that lacks the lock lets the source change.
- **Divider clearing.** It restarts counting after 31 ticks through the divide-by-32 stage. A design whose dividers keep their count in `CNT_IDLE` lets the counter advance by one.
- **Flags.** It wraps the counter from all ones, hits a flag with a set and a clear in the same cycle, and pulses the system reset with flags set. A wrong priority or a reset on the wrong input then loses a flag.

// File: rtl/rtc_front_pkg.sv
`timescale 1ns/1ps
package rtc_front_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int N_FLAG = 3;

    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

    // flag positions, LSB numbering; MSB-first positions 2, 18, 21
    localparam int RTCF_POS = DATA_W - 1 - 2;
    localparam int APIF_POS = DATA_W - 1 - 18;
    localparam int ROVF_POS = DATA_W - 1 - 21;

    localparam int FLAG_RTC = 0;
    localparam int FLAG_API = 1;
    localparam int FLAG_ROV = 2;

    typedef enum logic [1:0] {
        SRC_XTAL_SLOW = 2'b00,
        SRC_IRC_LOW   = 2'b01,
        SRC_IRC_HIGH  = 2'b10,
        SRC_XTAL_FAST = 2'b11
    } src_sel_e;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic     rov_ie;
        logic     api_ie;
        logic     rtc_ie;
        logic     div32_on;
        logic     div512_on;
        src_sel_e src_sel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic int flag_pos(input int idx);
        case (idx)
            FLAG_RTC: flag_pos = RTCF_POS;
            FLAG_API: flag_pos = APIF_POS;
            default:  flag_pos = ROVF_POS;
        endcase
    endfunction

endpackage

// File: rtl/rtc_src_mux.sv
`timescale 1ns/1ps
module rtc_src_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             tick_o
);

    logic [N_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
        end
    endgenerate

    assign tick_o = run && (|hit);

endmodule

// File: rtl/rtc_prescale.sv
`timescale 1ns/1ps
module rtc_prescale #(
    parameter int RATIO = 512,
    localparam int CW = $clog2(RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stage_on,
    input  logic tick_i,
    output logic tick_o
);

    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] div_q;
    logic          at_last;

    assign at_last = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || !stage_on) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= at_last ? '0 : div_q + 1'b1;
        end
    end

    always_comb begin
        if (stage_on) begin
            tick_o = tick_i && at_last;
        end else begin
            tick_o = tick_i;
        end
    end

endmodule

// File: rtl/rtc_tick_counter.sv
`timescale 1ns/1ps
module rtc_tick_counter
    import rtc_front_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick_i,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (cnt_en)  state_d = CNT_RUN;
            CNT_RUN:  if (!cnt_en) state_d = CNT_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CNT_IDLE: run_o = 1'b0;
            CNT_RUN:  run_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && !load_en && (&cnt_q);

endmodule

// File: rtl/rtc_status_flags.sv
`timescale 1ns/1ps
module rtc_status_flags
    import rtc_front_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [N_FLAG-1:0] set_i,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_data,
    output logic [N_FLAG-1:0] flags_o,
    output logic [DATA_W-1:0] word_o
);

    logic [N_FLAG-1:0] flag_q;

    generate
        for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
            localparam int POS = flag_pos(g);
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    flag_q[g] <= 1'b0;
                end else if (set_i[g]) begin
                    flag_q[g] <= 1'b1;
                end else if (clr_we && clr_data[POS]) begin
                    flag_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        word_o = '0;
        for (int i = 0; i < N_FLAG; i++) begin
            word_o[flag_pos(i)] = flag_q[i];
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/rtc_front.sv
`timescale 1ns/1ps
module rtc_front
    import rtc_front_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int DIV_A = 512,
    parameter int DIV_B = 32,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [N_SRC-1:0]  src_tick,
    input  logic              cnt_en,
    input  logic              rtc_match,
    input  logic              api_match,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int SEL_W = $clog2(N_SRC);

    cfg_t              cfg_q;
    cfg_t              cfg_w;
    logic              run;
    logic              tick_src, tick_a, tick_b;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap;
    logic [N_FLAG-1:0] flags;
    logic [N_FLAG-1:0] ie;
    logic [DATA_W-1:0] stat_word;
    logic              wr_cfg, wr_stat, wr_cnt;

    assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT) && !cnt_en;

    assign cfg_w = cfg_t'(bus_wdata[CFG_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q.rtc_ie <= cfg_w.rtc_ie;
            cfg_q.api_ie <= cfg_w.api_ie;
            cfg_q.rov_ie <= cfg_w.rov_ie;
            if (!cnt_en) begin
                cfg_q.src_sel   <= cfg_w.src_sel;
                cfg_q.div512_on <= cfg_w.div512_on;
                cfg_q.div32_on  <= cfg_w.div32_on;
            end
        end
    end

    rtc_src_mux #(.N_SRC(N_SRC)) u_mux (
        .src_tick (src_tick),
        .sel      (SEL_W'(cfg_q.src_sel)),
        .run      (run),
        .tick_o   (tick_src)
    );

    rtc_prescale #(.RATIO(DIV_A)) u_div_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!run),
        .stage_on (cfg_q.div512_on),
        .tick_i   (tick_src),
        .tick_o   (tick_a)
    );

    rtc_prescale #(.RATIO(DIV_B)) u_div_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!run),
        .stage_on (cfg_q.div32_on),
        .tick_i   (tick_a),
        .tick_o   (tick_b)
    );

    rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .tick_i   (tick_b),
        .load_en  (wr_cnt),
        .load_val (bus_wdata[CNT_W-1:0]),
        .run_o    (run),
        .cnt_o    (cnt_q),
        .wrap_o   (wrap)
    );

    rtc_status_flags u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .set_i    ({wrap, api_match, rtc_match}),
        .clr_we   (wr_stat),
        .clr_data (bus_wdata),
        .flags_o  (flags),
        .word_o   (stat_word)
    );

    assign ie  = {cfg_q.rov_ie, cfg_q.api_ie, cfg_q.rtc_ie};
    assign irq = |(flags & ie);

    always_comb begin
        unique case (bus_addr)
            ADDR_CFG:  bus_rdata = DATA_W'(cfg_q);
            ADDR_STAT: bus_rdata = stat_word;
            ADDR_CNT:  bus_rdata = DATA_W'(cnt_q);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_front_chk.sv
`timescale 1ns/1ps
module rtc_front_chk
    import rtc_front_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              cnt_en,
    input logic              rtc_match,
    input logic              api_match,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [31:0]       cnt_q,
    input logic [DATA_W-1:0] stat_word
);

    // R4
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> $stable(cfg_q[3:0]));

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CNT && !cnt_en) |=> (cnt_q == $past(bus_wdata)));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_CNT && !cnt_en)
        |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 32'd1));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr == ADDR_STAT && bus_wdata[APIF_POS] && !api_match)
        |=> !stat_word[APIF_POS]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        rtc_match |=> stat_word[RTCF_POS]);

    // R10
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (cnt_q == 32'd0 && $past(cnt_q) == 32'hFFFF_FFFF
         && !$past(bus_wr && bus_addr == ADDR_CNT && !cnt_en))
        |-> stat_word[ROVF_POS]);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (stat_word == '0 || cfg_q[6:4] == 3'b000) |-> !irq);

    // R7
    stat_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
        $countones(stat_word) <= 3);

endmodule

bind rtc_front rtc_front_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .cnt_en    (cnt_en),
    .rtc_match (rtc_match),
    .api_match (api_match),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cfg_q     (cfg_q),
    .cnt_q     (cnt_q),
    .stat_word (stat_word)
);

// File: tb/rtc_front_tb_top.sv
`timescale 1ns/1ps
module rtc_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        cnt_en = 1'b0;
    logic        rtc_match = 1'b0;
    logic        api_match = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_front dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .src_tick(src_tick),
        .cnt_en(cnt_en), .rtc_match(rtc_match), .api_match(api_match),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [6:0]  m_cfg;
    bit [31:0] m_cnt;
    bit [2:0]  m_flag;      // {rov, api, rtc}
    int        m_p1, m_p2;
    bit        m_run;

    function automatic bit [31:0] m_read(input bit [1:0] a);
        case (a)
            2'd0: return {25'd0, m_cfg};
            2'd1: return {2'b0, m_flag[0], 15'd0, m_flag[1], 2'b0, m_flag[2], 10'd0};
            2'd2: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit        s_wr, s_en, s_rm, s_am, t, rov;
        bit [1:0]  s_a;
        bit [31:0] s_d;
        bit [3:0]  s_t;
        bit [2:0]  clr;
        s_wr = bus_wr; s_a = bus_addr; s_d = bus_wdata; s_t = src_tick;
        s_en = cnt_en; s_rm = rtc_match; s_am = api_match;
        #1;
        rov = 1'b0;
        if (!rst_n) begin
            m_cfg = '0; m_cnt = '0; m_p1 = 0; m_p2 = 0; m_run = 1'b0;
        end else begin
            t = m_run && s_t[m_cfg[1:0]];
            if (!m_run || !m_cfg[2]) m_p1 = 0;
            else if (t) begin
                if (m_p1 == 511) m_p1 = 0; else begin m_p1++; t = 1'b0; end
            end
            if (!m_run || !m_cfg[3]) m_p2 = 0;
            else if (t) begin
                if (m_p2 == 31) m_p2 = 0; else begin m_p2++; t = 1'b0; end
            end
            if (s_wr && s_a == 2'd2 && !s_en) m_cnt = s_d;
            else if (t) begin
                if (m_cnt == 32'hFFFF_FFFF) rov = 1'b1;
                m_cnt = m_cnt + 1;
            end
            if (s_wr && s_a == 2'd0) begin
                m_cfg[6:4] = s_d[6:4];
                if (!s_en) m_cfg[3:0] = s_d[3:0];
            end
            m_run = s_en;
        end
        if (!por_n) m_flag = '0;
        else begin
            clr = (s_wr && s_a == 2'd1) ? {s_d[10], s_d[13], s_d[29]} : 3'b0;
            m_flag = (m_flag & ~clr) | {rov, s_am, s_rm};
        end
        case (bus_addr)
            2'd0: chk("R4 per-cycle config", bus_rdata, m_read(bus_addr));
            2'd1: chk("R7 per-cycle status", bus_rdata, m_read(bus_addr));
            2'd2: chk("R5 per-cycle counter", bus_rdata, m_read(bus_addr));
            default: chk("R6 per-cycle addr3", bus_rdata, m_read(bus_addr));
        endcase
        chk("R12 per-cycle irq", {31'd0, irq}, {31'd0, |(m_flag & m_cfg[6:4])});
    end

    task automatic wr(input bit [1:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd2;
    endtask

    task automatic rd(input string tag, input bit [1:0] a, input bit [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic run_ticks(input bit [6:0] cfg, input bit [3:0] pat, input int n, input bit reload);
        wr(2'd0, {25'd0, cfg});
        if (reload) wr(2'd2, 32'd0);
        @(negedge clk); cnt_en = 1'b1;
        @(negedge clk); src_tick = pat;
        repeat (n) @(negedge clk);
        src_tick = '0; cnt_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        rd("R11 reset config", 2'd0, 32'd0);
        rd("R11 reset status", 2'd1, 32'd0);
        rd("R6 reset counter", 2'd2, 32'd0);
        chk("R12 reset irq", {31'd0, irq}, 32'd0);

        run_ticks(7'h01, 4'b0010, 10, 1'b1);
        rd("R1 src1 counts", 2'd2, 32'd10);
        run_ticks(7'h01, 4'b1101, 20, 1'b1);
        rd("R1 unselected ignored", 2'd2, 32'd0);
        run_ticks(7'h03, 4'b1000, 7, 1'b1);
        rd("R1 src3 counts", 2'd2, 32'd7);
        run_ticks(7'h00, 4'b0001, 5, 1'b1);
        rd("R1 src0 counts", 2'd2, 32'd5);

        run_ticks(7'h04, 4'b0001, 1024, 1'b1);
        rd("R2 div512 x2", 2'd2, 32'd2);
        run_ticks(7'h04, 4'b0001, 1535, 1'b1);
        rd("R2 div512 short", 2'd2, 32'd2);
        run_ticks(7'h0A, 4'b0100, 96, 1'b1);
        rd("R3 div32", 2'd2, 32'd3);
        run_ticks(7'h0C, 4'b0001, 32767, 1'b1);
        rd("R3 cascade 16384", 2'd2, 32'd1);

        run_ticks(7'h08, 4'b0001, 31, 1'b1);
        run_ticks(7'h08, 4'b0001, 31, 1'b0);
        rd("R5 divider cleared in idle", 2'd2, 32'd0);

        wr(2'd0, 32'h01);
        @(negedge clk); cnt_en = 1'b1;
        wr(2'd0, 32'h7E);
        rd("R4 locked fields", 2'd0, 32'h71);
        wr(2'd2, 32'h55);
        rd("R6 load ignored while counting", 2'd2, 32'd0);
        @(negedge clk); cnt_en = 1'b0;
        rd("R6 addr3 reads zero", 2'd3, 32'd0);

        wr(2'd2, 32'hFFFF_FFFF);
        rd("R6 load while stopped", 2'd2, 32'hFFFF_FFFF);
        run_ticks(7'h01, 4'b0010, 1, 1'b0);
        rd("R10 wrap to zero", 2'd2, 32'd0);
        rd("R10 rollover flag", 2'd1, 32'h0000_0400);
        chk("R12 masked irq", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h40);
        #1 chk("R12 rollover irq", {31'd0, irq}, 32'd1);

        wr(2'd1, 32'hDFFF_DBFF);
        rd("R8 write zero keeps", 2'd1, 32'h0000_0400);
        wr(2'd1, 32'h0000_0400);
        rd("R8 write one clears", 2'd1, 32'd0);
        chk("R12 irq drops", {31'd0, irq}, 32'd0);

        @(negedge clk); api_match = 1'b1;
        @(negedge clk); api_match = 1'b0;
        rd("R7 wake-up flag bit13", 2'd1, 32'h0000_2000);
        @(negedge clk); rtc_match = 1'b1;
        @(negedge clk); rtc_match = 1'b0;
        rd("R7 rtc flag bit29", 2'd1, 32'h2000_2000);

        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h2000_0000; rtc_match = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rtc_match = 1'b0;
        rd("R9 set beats clear", 2'd1, 32'h2000_2000);
        wr(2'd0, 32'h30);
        #1 chk("R12 flag irq", {31'd0, irq}, 32'd1);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd("R11 flags survive rst_n", 2'd1, 32'h2000_2000);
        rd("R11 config cleared", 2'd0, 32'd0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd("R11 por clears flags", 2'd1, 32'd0);

        // mixed random traffic, checked every cycle by the model
        wr(2'd0, 32'h7A);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src_tick  = 4'($urandom);
            rtc_match = ($urandom % 16) == 0;
            api_match = ($urandom % 16) == 0;
            bus_wr    = ($urandom % 6) == 0;
            bus_addr  = 2'($urandom);
            bus_wdata = $urandom;
            if (($urandom % 40) == 0) cnt_en = ~cnt_en;
        end
        @(negedge clk);
        src_tick = '0; rtc_match = 1'b0; api_match = 1'b0; bus_wr = 1'b0; cnt_en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule